// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates interrupt requests for a small microcontroller core. Nine sources raise requests. The four wakeup pins form one group. The other sources are two external lines, four timers, a serial port and an A/D converter. Each source has a pending flag and a mask bit, and a single global enable gates all of them. A source asks for service when its flag is 1 and its mask is 0. A fixed priority then picks the winner, and the block turns it into an even vector address. Two pairs of sources share a vector (timer B with timer D, and the serial port with the A/D converter). Software tells them apart by reading the individual flags.

When the global enable is 1 and a request is present, a three-cycle entry sequence runs, and its states are named:
- `ST_FINISH`: the core completes its current instruction.
- `ST_SAVE`: the enable has just been cleared and the vector latched, and the core pushes the first half of its state.
- `ST_JUMP`: the core pushes the second half and loads the PC with the vector.

The rest state is `ST_IDLE`. The transitions are:
- *accept*: `ST_IDLE` to `ST_FINISH`.
- *commit*: `ST_FINISH` to `ST_SAVE`, taken when a request is still present.
- *withdraw*: `ST_FINISH` to `ST_IDLE`, taken when no request is left.
- *advance*: `ST_SAVE` to `ST_JUMP`.
- *resume*: `ST_JUMP` to `ST_IDLE`.

Control bits sit in six nibble-wide registers at addresses 0x00 to 0x03, 0x22 and 0x23. They are written one bit at a time with set and clear operations, and read a nibble at a time. The controller never clears a pending flag by itself.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the enable is 0, all nine flags are 0, all nine masks are 1 and the sequencer is idle (`take_req`, `push_en`, `pc_load` low).
- R2: A rising edge on any wakeup pin sets the flag of source 0. A rising edge on `evt_in[k]` sets the flag of source k+1. The flag reads 1 after the clock edge that samples the edge. The source order is 0 wakeup, 1 ext0, 2 ext1, 3 timer A, 4 timer B, 5 timer C, 6 timer D, 7 serial, 8 A/D.
- R3: A bit write with value 0 clears a flag. A bit write with value 1 leaves a flag unchanged. A hardware set and a software clear of the same flag on the same edge leave it at 1.
- R4: The register layout uses a flat bit index f = 4*page + bit, where pages 0 to 3 sit at addresses 0x00 to 0x03, page 4 at 0x22 and page 5 at 0x23. Bit f=0 is the enable, f=1+2s is the flag of source s and f=2+2s is its mask. The enable and the masks follow bit writes. Writes to other addresses change nothing, and unused bits and other addresses read 0.
- R5: The sequence starts only when the enable is 1 and some source has flag 1 and mask 0.
- R6: The vector is twice the priority number of the winning group, and the lowest number wins. The priorities are: wakeup 1, ext0 2, ext1 3, timer A 4, timers B and D 5, timer C 6, serial and A/D 7.
- R7: One clock after the enable and a request meet, `take_req` is high for one cycle. Next comes a cycle with `push_en`=1 and `push_step`=0 in which the enable reads 0. Then a cycle with `push_en`=1, `push_step`=1 and `pc_load`=1. The block then returns to idle.
- R8: The vector is latched at the entry to the save cycle. A request that arrives later does not change the vector presented with `pc_load`.
- R9: The controller never clears a flag. Flags remain set through and after the entry sequence.
- R10: If no request remains in the finish cycle, the sequence returns to idle without pushing, and the enable stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_pin | input | 4 | Wakeup pins, rising edge sets source 0 |
| evt_in | input | 8 | Event inputs for sources 1 to 8, rising edge |
| bit_we | input | 1 | Single-bit write strobe |
| bit_val | input | 1 | Value written (1 set, 0 clear) |
| bit_addr | input | 6 | Register address of the write |
| bit_sel | input | 2 | Bit within the addressed nibble |
| rd_addr | input | 6 | Register address to read |
| rd_data | output | 4 | Nibble at `rd_addr` |
| take_req | output | 1 | Finish-cycle indication to the core |
| push_en | output | 1 | Push strobe for the core's stack logic |
| push_step | output | 2 | Push step index (0, then 1) |
| pc_load | output | 1 | One-cycle PC load pulse |
| vec_addr | output | 14 | Latched vector address |

## Verification
The hardest case to reach is a request that appears inside the entry sequence itself. A higher-priority edge must land exactly on the edge that latches the vector, and a pending request must vanish exactly on the edge that enters the finish cycle. The bench reaches both by timing its pin and write stimulus against `take_req`, using back-to-back single-bit writes. Two sweeps then cover priority resolution. One sweeps all 512 pending patterns with every mask open. The other sweeps all 512 mask patterns with every flag pending.

// File: rtl/pvi_pkg.sv
package pvi_pkg;
    localparam int NSRC   = 9;
    localparam int NWAKE  = 4;
    localparam int NEVT   = NSRC - 1;
    localparam int NPAGE  = 6;
    localparam int NSLOT  = 4 * NPAGE;
    localparam int ADDR_W = 6;
    localparam int VEC_W  = 14;
    localparam int NPRIO  = 7;

    typedef logic [2:0] prio_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FINISH,
        ST_SAVE,
        ST_JUMP
    } seq_state_e;

    // Priority group of each source (1 = most urgent).
    function automatic prio_t src_prio(int s);
        case (s)
            0:       return 3'd1;
            1:       return 3'd2;
            2:       return 3'd3;
            3:       return 3'd4;
            4:       return 3'd5;
            5:       return 3'd6;
            6:       return 3'd5;
            default: return 3'd7;
        endcase
    endfunction

    // Returns {valid, page index}.
    function automatic logic [3:0] page_dec(logic [ADDR_W-1:0] a);
        case (a)
            6'h00:   return 4'b1_000;
            6'h01:   return 4'b1_001;
            6'h02:   return 4'b1_010;
            6'h03:   return 4'b1_011;
            6'h22:   return 4'b1_100;
            6'h23:   return 4'b1_101;
            default: return 4'b0_000;
        endcase
    endfunction
endpackage

// File: rtl/pvi_edge.sv
module pvi_edge #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_rise
            assign rise[i] = lvl[i] & ~prev_q[i];
        end
    endgenerate
endmodule

// File: rtl/pvi_regs.sv
module pvi_regs
    import pvi_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  hw_set,
    input  logic          we,
    input  logic          wval,
    input  logic [AW-1:0] waddr,
    input  logic [1:0]    wsel,
    input  logic          ie_clr,
    input  logic [AW-1:0] raddr,
    output logic [3:0]    rdata,
    output logic          ie,
    output logic [N-1:0]  flags,
    output logic [N-1:0]  masks
);
    localparam int SLOTS = NSLOT;

    logic [3:0]       wdec, rdec;
    logic [SLOTS-1:0] wr_hit;
    logic [SLOTS-1:0] flat;
    logic [N-1:0]     if_hit, im_hit;

    assign wdec = page_dec(waddr);
    assign rdec = page_dec(raddr);

    always_comb begin
        wr_hit = '0;
        if (we && wdec[3]) wr_hit[{wdec[2:0], wsel}] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         ie <= 1'b0;
        else if (ie_clr)    ie <= 1'b0;
        else if (wr_hit[0]) ie <= wval;
    end

    genvar s;
    generate
        for (s = 0; s < N; s++) begin : g_src
            assign if_hit[s] = wr_hit[1 + 2*s];
            assign im_hit[s] = wr_hit[2 + 2*s];

            always_ff @(posedge clk) begin
                if (!rst_n)                   flags[s] <= 1'b0;
                else if (hw_set[s])           flags[s] <= 1'b1;
                else if (if_hit[s] && !wval)  flags[s] <= 1'b0;
            end

            always_ff @(posedge clk) begin
                if (!rst_n)         masks[s] <= 1'b1;
                else if (im_hit[s]) masks[s] <= wval;
            end

            assign flat[1 + 2*s] = flags[s];
            assign flat[2 + 2*s] = masks[s];
        end
        for (s = 2*N + 1; s < SLOTS; s++) begin : g_spare
            assign flat[s] = 1'b0;
        end
    endgenerate

    assign flat[0] = ie;
    assign rdata   = rdec[3] ? flat[{rdec[2:0], 2'b00} +: 4] : 4'h0;
endmodule

// File: rtl/pvi_prio.sv
module pvi_prio
    import pvi_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int VW = VEC_W,
    parameter int NP = NPRIO
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [VW-1:0] vec
);
    logic [NP:0] grp;

    always_comb begin
        grp = '0;
        for (int s = 0; s < N; s++) begin
            if (req[s]) grp[src_prio(s)] = 1'b1;
        end
    end

    // Scan from the least urgent group so the most urgent one is written last.
    always_comb begin
        vec = '0;
        for (int g = NP; g >= 0; g--) begin
            if (grp[3'(g)]) vec = VW'(2 * g);
        end
    end

    assign any = |req;
endmodule

// File: rtl/pvi_seq.sv
module pvi_seq
    import pvi_pkg::*;
#(
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ie,
    input  logic          any_req,
    input  logic [VW-1:0] win_vec,
    output logic          take_req,
    output logic          push_en,
    output logic [1:0]    push_step,
    output logic          pc_load,
    output logic          ie_clr,
    output logic [VW-1:0] vec_addr
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (ie && any_req) state_d = ST_FINISH;            // accept
            ST_FINISH: state_d = any_req ? ST_SAVE : ST_IDLE;             // commit / withdraw
            ST_SAVE:   state_d = ST_JUMP;                                 // advance
            ST_JUMP:   state_d = ST_IDLE;                                 // resume
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take_req  = 1'b0;
        push_en   = 1'b0;
        push_step = 2'd0;
        pc_load   = 1'b0;
        ie_clr    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_FINISH: begin
                take_req = 1'b1;
                ie_clr   = any_req;
            end
            ST_SAVE:   push_en = 1'b1;
            ST_JUMP: begin
                push_en   = 1'b1;
                push_step = 2'd1;
                pc_load   = 1'b1;
            end
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      vec_addr <= '0;
        else if (ie_clr) vec_addr <= win_vec;
    end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import pvi_pkg::*;
#(
    parameter int NW = NWAKE,
    parameter int NE = NEVT,
    parameter int AW = ADDR_W,
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] wake_pin,
    input  logic [NE-1:0] evt_in,
    input  logic          bit_we,
    input  logic          bit_val,
    input  logic [AW-1:0] bit_addr,
    input  logic [1:0]    bit_sel,
    input  logic [AW-1:0] rd_addr,
    output logic [3:0]    rd_data,
    output logic          take_req,
    output logic          push_en,
    output logic [1:0]    push_step,
    output logic          pc_load,
    output logic [VW-1:0] vec_addr
);
    localparam int NIN = NW + NE;
    localparam int NS  = NE + 1;

    logic [NIN-1:0] rise;
    logic [NS-1:0]  hw_set;
    logic [NS-1:0]  flag_w, mask_w;
    logic           ie_w, ie_clr_w, any_w;
    logic [VW-1:0]  win_vec_w;

    pvi_edge #(.W(NIN)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({evt_in, wake_pin}),
        .rise (rise)
    );

    assign hw_set = {rise[NIN-1:NW], |rise[NW-1:0]};

    pvi_regs #(.N(NS), .AW(AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .hw_set(hw_set),
        .we    (bit_we),
        .wval  (bit_val),
        .waddr (bit_addr),
        .wsel  (bit_sel),
        .ie_clr(ie_clr_w),
        .raddr (rd_addr),
        .rdata (rd_data),
        .ie    (ie_w),
        .flags (flag_w),
        .masks (mask_w)
    );

    pvi_prio #(.N(NS), .VW(VW), .NP(NPRIO)) u_prio (
        .req(flag_w & ~mask_w),
        .any(any_w),
        .vec(win_vec_w)
    );

    pvi_seq #(.VW(VW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ie       (ie_w),
        .any_req  (any_w),
        .win_vec  (win_vec_w),
        .take_req (take_req),
        .push_en  (push_en),
        .push_step(push_step),
        .pc_load  (pc_load),
        .ie_clr   (ie_clr_w),
        .vec_addr (vec_addr)
    );
endmodule

// File: rtl/pvi_checker.sv
module pvi_checker #(
    parameter int NS = 9,
    parameter int VW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_we,
    input logic          take_req,
    input logic          push_en,
    input logic [1:0]    push_step,
    input logic          pc_load,
    input logic [VW-1:0] vec_addr,
    input logic          ie_q,
    input logic [NS-1:0] flag_q
);
    a_r5_accept_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_req) |-> $past(ie_q));

    a_r7_save_then_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && push_step == 2'd0) |=> (push_en && push_step == 2'd1 && pc_load));

    a_r7_enable_low_in_save: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && push_step == 2'd0) |-> !ie_q);

    a_r7_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_req, push_en}));

    a_r8_vector_held: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> vec_addr == $past(vec_addr));

    a_r6_vector_legal: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (vec_addr[0] == 1'b0 && vec_addr != '0 && vec_addr <= VW'(14)));

    a_r9_flags_never_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_we |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

bind prio_vec_intc pvi_checker #(.NS(9), .VW(14)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_we   (bit_we),
    .take_req (take_req),
    .push_en  (push_en),
    .push_step(push_step),
    .pc_load  (pc_load),
    .vec_addr (vec_addr),
    .ie_q     (ie_w),
    .flag_q   (flag_w)
);

// File: tb/tb_prio_vec_intc.sv
`timescale 1ns/1ps
module tb_prio_vec_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  wake_pin = '0;
    logic [7:0]  evt_in = '0;
    logic        bit_we = 1'b0, bit_val = 1'b0;
    logic [5:0]  bit_addr = '0, rd_addr = '0;
    logic [1:0]  bit_sel = '0;
    logic [3:0]  rd_data;
    logic        take_req, push_en, pc_load;
    logic [1:0]  push_step;
    logic [13:0] vec_addr;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic       m_ie;
    logic [8:0] m_if, m_im;
    int prio_of [9] = '{1, 2, 3, 4, 5, 6, 5, 7, 7};

    always #5 clk = ~clk;

    prio_vec_intc dut (
        .clk(clk), .rst_n(rst_n), .wake_pin(wake_pin), .evt_in(evt_in),
        .bit_we(bit_we), .bit_val(bit_val), .bit_addr(bit_addr), .bit_sel(bit_sel),
        .rd_addr(rd_addr), .rd_data(rd_data), .take_req(take_req), .push_en(push_en),
        .push_step(push_step), .pc_load(pc_load), .vec_addr(vec_addr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] addr_of(int pg);
        return (pg < 4) ? 6'(pg) : 6'(32'h22 + pg - 4);
    endfunction

    function automatic logic [3:0] exp_nib(int pg);
        logic [23:0] f = '0;
        f[0] = m_ie;
        for (int s = 0; s < 9; s++) begin
            f[1 + 2*s] = m_if[s];
            f[2 + 2*s] = m_im[s];
        end
        return f[pg*4 +: 4];
    endfunction

    function automatic logic [13:0] exp_vec(logic [8:0] req);
        int best = 8;
        for (int s = 0; s < 9; s++) if (req[s] && prio_of[s] < best) best = prio_of[s];
        return 14'(2 * best);
    endfunction

    task automatic sw(input int f, input bit v);
        @(negedge clk);
        bit_we = 1'b1; bit_val = v; bit_addr = addr_of(f / 4); bit_sel = 2'(f % 4);
        @(negedge clk);
        bit_we = 1'b0;
        if (f == 0) m_ie = v;
        else if (f % 2 == 1) begin if (!v) m_if[(f-1)/2] = 1'b0; end
        else m_im[(f-2)/2] = v;
    endtask

    task automatic read_all(input string req);
        for (int pg = 0; pg < 6; pg++) begin
            @(negedge clk);
            rd_addr = addr_of(pg);
            #1;
            check(rd_data == exp_nib(pg), req, rd_data, exp_nib(pg));
        end
        rd_addr = '0;
    endtask

    task automatic fire(input logic [8:0] srcs, input int wk);
        @(negedge clk);
        wake_pin = srcs[0] ? 4'(1 << wk) : 4'h0;
        evt_in   = srcs[8:1];
        @(negedge clk);
        wake_pin = '0; evt_in = '0;
        m_if = m_if | srcs;
    endtask

    task automatic clear_flags();
        for (int s = 0; s < 9; s++) if (m_if[s]) sw(1 + 2*s, 1'b0);
    endtask

    // Called at the negedge right after the edge that set the enable.
    task automatic expect_entry(input logic [13:0] v, input string req);
        rd_addr = 6'h00;
        @(negedge clk);
        check(take_req && !push_en, {req, " R7 finish"}, {take_req, push_en}, 2'b10);
        @(negedge clk);
        check(push_en && push_step == 0 && !pc_load && !take_req, {req, " R7 save"},
              {push_en, push_step, pc_load}, 4'b1000);
        check(rd_data[0] == 1'b0, {req, " R7 enable cleared"}, rd_data[0], 0);
        @(negedge clk);
        check(push_en && push_step == 1 && pc_load, {req, " R7 jump"},
              {push_en, push_step, pc_load}, 4'b1011);
        check(vec_addr == v, {req, " R6 vector"}, vec_addr, v);
        @(negedge clk);
        check(!take_req && !push_en && !pc_load, {req, " R7 idle"},
              {take_req, push_en, pc_load}, 0);
        m_ie = 1'b0;
    endtask

    task automatic expect_none(input string req);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(!take_req && !push_en && !pc_load, req, {take_req, push_en, pc_load}, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_ie = 1'b0; m_if = '0; m_im = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_all("R1");
        check(!take_req && !push_en && !pc_load, "R1 idle", {take_req, push_en, pc_load}, 0);

        // R2 every event input, then R3 software clear
        for (int i = 0; i < 12; i++) begin
            if (i < 4) fire(9'h001, i);
            else       fire(9'(1 << (i - 3)), 0);
            read_all("R2");
            clear_flags();
            read_all("R3 clear");
        end

        // R3 software set ignored
        for (int s = 0; s < 9; s++) sw(1 + 2*s, 1'b1);
        read_all("R3 set ignored");

        // R3 hardware set beats same-edge clear
        @(negedge clk);
        evt_in = 8'h01; bit_we = 1'b1; bit_val = 1'b0; bit_addr = addr_of(0); bit_sel = 2'd3;
        @(negedge clk);
        evt_in = '0; bit_we = 1'b0; m_if[1] = 1'b1;
        read_all("R3 set wins");
        clear_flags();

        // R4 masks and enable, out-of-window writes
        for (int s = 0; s < 9; s++) begin
            sw(2 + 2*s, 1'b0); read_all("R4 mask clear");
            sw(2 + 2*s, 1'b1);
        end
        sw(0, 1'b1); read_all("R4 enable set");
        expect_none("R5 no request");
        sw(0, 1'b0);
        for (int a = 4; a < 64; a += 7) begin
            for (int b = 0; b < 4; b++) begin
                @(negedge clk);
                bit_we = 1'b1; bit_val = 1'b0; bit_addr = 6'(a); bit_sel = 2'(b);
            end
        end
        @(negedge clk); bit_we = 1'b0;
        read_all("R4 outside window");

        // R5/R6 sweep of pending patterns, masks open
        for (int s = 0; s < 9; s++) sw(2 + 2*s, 1'b0);
        for (int p = 0; p < 512; p++) begin
            fire(9'(p), p % 4);
            sw(0, 1'b1);
            if (p == 0) begin
                expect_none("R5 nothing pending");
                sw(0, 1'b0);
            end else begin
                expect_entry(exp_vec(9'(p)), "R6 pending sweep");
            end
            clear_flags();
        end

        // R5/R6 sweep of mask patterns, all flags pending
        fire(9'h1FF, 2);
        for (int m = 0; m < 512; m++) begin
            for (int s = 0; s < 9; s++)
                if (m_im[s] != m[s]) sw(2 + 2*s, m[s]);
            sw(0, 1'b1);
            if (m == 511) begin
                expect_none("R5 all masked");
                sw(0, 1'b0);
            end else begin
                expect_entry(exp_vec(~9'(m)), "R6 mask sweep");
            end
        end
        read_all("R9 flags kept");
        for (int s = 0; s < 9; s++) sw(2 + 2*s, 1'b0);
        clear_flags();

        // R8 late higher-priority request during the finish cycle
        fire(9'h100, 0);
        sw(0, 1'b1);
        @(negedge clk);
        check(take_req, "R8 finish", take_req, 1);
        wake_pin = 4'h1;
        @(negedge clk);
        wake_pin = '0;
        check(push_en && push_step == 0, "R8 save", {push_en, push_step}, 3'b100);
        @(negedge clk);
        check(pc_load && vec_addr == 14'h00E, "R8 vector unchanged", vec_addr, 14'h00E);
        @(negedge clk);
        m_ie = 1'b0; m_if[0] = 1'b1;
        read_all("R9 flags after entry");
        clear_flags();

        // R10 request withdrawn before the finish cycle ends
        fire(9'h100, 0);
        @(negedge clk);
        bit_we = 1'b1; bit_val = 1'b1; bit_addr = 6'h00; bit_sel = 2'd0;
        @(negedge clk);
        bit_val = 1'b0; bit_addr = addr_of(17 / 4); bit_sel = 2'(17 % 4);
        @(negedge clk);
        bit_we = 1'b0;
        check(take_req, "R10 finish entered", take_req, 1);
        @(negedge clk);
        check(!take_req && !push_en && !pc_load, "R10 withdraw", {take_req, push_en, pc_load}, 0);
        @(negedge clk);
        check(!push_en && !pc_load, "R10 stays idle", {push_en, pc_load}, 0);
        m_ie = 1'b1; m_if[8] = 1'b0;
        read_all("R10 enable kept");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule